// File: doc/BRIEF.md
# Delta-Panel Horizontal Drive Timing Generator

This block produces the horizontal drive pattern for a small active-matrix LCD panel whose colour dots sit in a delta arrangement. It runs from a base clock at four times the shift-clock rate. From that clock it produces a start pulse for the panel's horizontal shift register and two complementary shift clocks, each with a 50% duty cycle. Each line is started by a one-cycle line sync. At that sync the block samples an aspect select (wide 16:9 or narrow 4:3) and a scan-direction select, and holds both for the rest of the line.

In a delta layout, dots that share a signal line sit one and a half dots apart on adjacent rows. To match this, the start pulse and the whole clock burst are delayed by one and a half shift-clock bits (six base ticks) on every other line. In wide mode the line clocks 357 shift stages. In narrow mode it clocks 269 stages, centred in the same span, and a side-black window covers the 44 unused bit periods on each side. A polarity flag flips with every line. The panel needs line-inverted video, and the side-black drive follows the same flag.

Top module: `delta_hdrive_gen`

## Requirements
- R1: While reset is high, and after reset until the first line sync, the outputs sit idle: `hst`=0, `hck1`=0, `hck2`=1, `sideBlack`=0, `linePol`=0, `scanDir`=0.
- R2: `hck2` is always the inverse of `hck1`. During a burst, each bit lasts 4 base ticks, with `hck1` high for the first 2 and low for the last 2.
- R3: `hst` is high for exactly 4 ticks. It rises one tick before the first rising edge of `hck1` in the line, which gives the shift register its setup time.
- R4: In wide mode (select=1), `hst` first reads high after the 3rd rising edge that follows the edge sampling the sync (the 9th when the line is delayed), and the burst has 357 `hck1` rising edges.
- R5: In narrow mode (select=0), `hst` comes 176 ticks (44 bits) later than it would in wide mode, and the burst has 269 `hck1` rising edges.
- R6: In narrow mode, `sideBlack` is high for the first 176 ticks of the 1428-tick span and again for its last 176 ticks, never together with `hst` or a high `hck1`. In wide mode it stays low.
- R7: With right scan (select=1), odd lines are delayed by 6 ticks and even lines are not. With left scan (select=0), the reverse holds. The first line after reset counts as odd.
- R8: `linePol` flips two edges after each sampled line sync. It reads 1 on the first line after reset.
- R9: `scanDir` shows the scan select sampled at the line sync, starting with that line's first output.
- R10: Changes on the aspect and direction selects between syncs have no effect on the current line.
- R11: A line sync that arrives mid-line abandons the running line and starts the new one at once.
- R12: Once a line's span has ended, all drive outputs return to idle until the next sync. `linePol` and `scanDir` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, four ticks per shift-clock bit |
| rst | input | 1 | Synchronous reset, active high |
| lineSync | input | 1 | One-cycle pulse that starts a line |
| wideSel | input | 1 | Aspect select, 1 = 16:9, 0 = 4:3 |
| rightSel | input | 1 | Scan select, 1 = right, 0 = left |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Shift clock, phase one |
| hck2 | output | 1 | Shift clock, phase two |
| sideBlack | output | 1 | Side-black window in 4:3 mode |
| linePol | output | 1 | Per-line video and side-black polarity |
| scanDir | output | 1 | Latched scan direction for the panel |

## Verification
The assertions check the following on every cycle:
- the two clocks stay complementary;
- each clock high phase lasts two ticks;
- the start pulse leads the first clock edge by one tick;
- side-black never overlaps the start pulse, a high clock, or wide mode;
- the polarity flips only, and always, two edges after a sync.

Only the bench's scenarios can show the parts that need a full line of context:
- the stage counts for each aspect;
- the exact placement of the 44-bit margins;
- which line parity carries the 1.5-bit delay in each scan direction;
- that select changes mid-line are ignored;
- that a late sync or a reset truncates a line cleanly.

// File: rtl/dhg_pkg.sv
package dhg_pkg;

  // Strobes handed from the line control to the output register stage.
  typedef struct packed {
    logic hstWin;    // start pulse window
    logic runWin;    // shift clock burst active
    logic clkHigh;   // first half of the current bit
    logic blackWin;  // side-black margin window
    logic parity;    // line parity / drive polarity
    logic dirRight;  // latched scan direction
  } hStrobe_t;

endpackage

// File: rtl/dhg_window.sv
module dhg_window #(
  parameter int BIT_TICKS     = 4,
  parameter int WIDE_STAGES   = 357,
  parameter int NARROW_STAGES = 269,
  parameter int LEAD_TICKS    = 2,
  parameter int SETUP_TICKS   = 1,
  parameter int CNT_W         = 11
) (
  input  logic [CNT_W-1:0] tickCnt,
  input  logic             running,
  input  logic             delayed,
  input  logic             wide,
  output logic             hstWin,
  output logic             runWin,
  output logic             clkHigh,
  output logic             blackWin
);

  localparam int DELTA_TICKS = BIT_TICKS + BIT_TICKS / 2;
  localparam int PAD_BITS    = (WIDE_STAGES - NARROW_STAGES) / 2;

  localparam logic [CNT_W-1:0] START_NEAR  = CNT_W'(LEAD_TICKS);
  localparam logic [CNT_W-1:0] START_FAR   = CNT_W'(LEAD_TICKS + DELTA_TICKS);
  localparam logic [CNT_W-1:0] PAD_TICKS   = CNT_W'(PAD_BITS * BIT_TICKS);
  localparam logic [CNT_W-1:0] WIDE_RUN    = CNT_W'(WIDE_STAGES * BIT_TICKS);
  localparam logic [CNT_W-1:0] NARROW_RUN  = CNT_W'(NARROW_STAGES * BIT_TICKS);
  localparam logic [CNT_W-1:0] TRAIL_START = CNT_W'((PAD_BITS + NARROW_STAGES) * BIT_TICKS);
  localparam logic [CNT_W-1:0] SETUP       = CNT_W'(SETUP_TICKS);
  localparam logic [CNT_W-1:0] BIT_LEN     = CNT_W'(BIT_TICKS);
  localparam logic [CNT_W-1:0] HALF_LEN    = CNT_W'(BIT_TICKS / 2);

  logic [CNT_W-1:0] spanStart;
  logic [CNT_W-1:0] sRel;
  logic [CNT_W-1:0] hstOfs;
  logic [CNT_W-1:0] runLen;
  logic [CNT_W-1:0] qRel;
  logic [CNT_W-1:0] bitPos;
  logic             inSpan;
  logic             afterHst;

  always_comb begin
    spanStart = delayed ? START_FAR : START_NEAR;
    inSpan    = running && (tickCnt >= spanStart);
    sRel      = tickCnt - spanStart;
    hstOfs    = wide ? '0 : PAD_TICKS;
    runLen    = wide ? WIDE_RUN : NARROW_RUN;
    afterHst  = inSpan && (sRel >= hstOfs);
    qRel      = sRel - hstOfs;
    bitPos    = (qRel - SETUP) % BIT_LEN;

    hstWin   = afterHst && (qRel < BIT_LEN);
    runWin   = afterHst && (qRel >= SETUP) && (qRel < SETUP + runLen);
    clkHigh  = bitPos < HALF_LEN;
    blackWin = inSpan && !wide &&
               ((sRel < PAD_TICKS) || ((sRel >= TRAIL_START) && (sRel < WIDE_RUN)));
  end

endmodule

// File: rtl/dhg_ctrl.sv
module dhg_ctrl
  import dhg_pkg::*;
#(
  parameter int BIT_TICKS     = 4,
  parameter int WIDE_STAGES   = 357,
  parameter int NARROW_STAGES = 269,
  parameter int LEAD_TICKS    = 2,
  parameter int SETUP_TICKS   = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     lineSync,
  input  logic     wideSel,
  input  logic     rightSel,
  output hStrobe_t strobe,
  output logic     modeWideQ
);

  localparam int DELTA_TICKS = BIT_TICKS + BIT_TICKS / 2;
  localparam int LAST_TICK   = LEAD_TICKS + DELTA_TICKS + SETUP_TICKS + WIDE_STAGES * BIT_TICKS;
  localparam int CNT_W       = $clog2(LAST_TICK + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LAST_TICK);

  logic [CNT_W-1:0] tickCnt;
  logic             running;
  logic             parityQ;
  logic             rightQ;
  logic             delayed;
  logic             hstWin, runWin, clkHigh, blackWin;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt   <= '0;
      running   <= 1'b0;
      parityQ   <= 1'b0;
      modeWideQ <= 1'b0;
      rightQ    <= 1'b0;
    end else if (lineSync) begin
      tickCnt   <= '0;
      running   <= 1'b1;
      parityQ   <= ~parityQ;
      modeWideQ <= wideSel;
      rightQ    <= rightSel;
    end else if (running && (tickCnt != LAST_CNT)) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Right scan delays odd lines, left scan delays even lines.
  assign delayed = (parityQ == rightQ);

  dhg_window #(
    .BIT_TICKS    (BIT_TICKS),
    .WIDE_STAGES  (WIDE_STAGES),
    .NARROW_STAGES(NARROW_STAGES),
    .LEAD_TICKS   (LEAD_TICKS),
    .SETUP_TICKS  (SETUP_TICKS),
    .CNT_W        (CNT_W)
  ) win_i (
    .tickCnt (tickCnt),
    .running (running),
    .delayed (delayed),
    .wide    (modeWideQ),
    .hstWin  (hstWin),
    .runWin  (runWin),
    .clkHigh (clkHigh),
    .blackWin(blackWin)
  );

  always_comb begin
    strobe.hstWin   = hstWin;
    strobe.runWin   = runWin;
    strobe.clkHigh  = clkHigh;
    strobe.blackWin = blackWin;
    strobe.parity   = parityQ;
    strobe.dirRight = rightQ;
  end

endmodule

// File: rtl/dhg_dp.sv
module dhg_dp
  import dhg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  hStrobe_t strobe,
  output logic     hst,
  output logic     hck1,
  output logic     hck2,
  output logic     sideBlack,
  output logic     linePol,
  output logic     scanDir
);

  logic clkDrive;

  assign clkDrive = strobe.runWin & strobe.clkHigh;

  always_ff @(posedge clk) begin
    if (rst) begin
      hst       <= 1'b0;
      hck1      <= 1'b0;
      hck2      <= 1'b1;
      sideBlack <= 1'b0;
      linePol   <= 1'b0;
      scanDir   <= 1'b0;
    end else begin
      hst       <= strobe.hstWin;
      hck1      <= clkDrive;
      hck2      <= ~clkDrive;
      sideBlack <= strobe.blackWin;
      linePol   <= strobe.parity;
      scanDir   <= strobe.dirRight;
    end
  end

endmodule

// File: rtl/delta_hdrive_gen.sv
module delta_hdrive_gen
  import dhg_pkg::*;
#(
  parameter int BIT_TICKS     = 4,
  parameter int WIDE_STAGES   = 357,
  parameter int NARROW_STAGES = 269,
  parameter int LEAD_TICKS    = 2,
  parameter int SETUP_TICKS   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic lineSync,
  input  logic wideSel,
  input  logic rightSel,
  output logic hst,
  output logic hck1,
  output logic hck2,
  output logic sideBlack,
  output logic linePol,
  output logic scanDir
);

  hStrobe_t strobe;
  logic     modeWideQ;

  dhg_ctrl #(
    .BIT_TICKS    (BIT_TICKS),
    .WIDE_STAGES  (WIDE_STAGES),
    .NARROW_STAGES(NARROW_STAGES),
    .LEAD_TICKS   (LEAD_TICKS),
    .SETUP_TICKS  (SETUP_TICKS)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .lineSync (lineSync),
    .wideSel  (wideSel),
    .rightSel (rightSel),
    .strobe   (strobe),
    .modeWideQ(modeWideQ)
  );

  dhg_dp dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .hst      (hst),
    .hck1     (hck1),
    .hck2     (hck2),
    .sideBlack(sideBlack),
    .linePol  (linePol),
    .scanDir  (scanDir)
  );

endmodule

// File: rtl/dhg_checker.sv
module dhg_checker (
  input logic clk,
  input logic rst,
  input logic lineSync,
  input logic modeWide,
  input logic hst,
  input logic hck1,
  input logic hck2,
  input logic sideBlack,
  input logic linePol
);

  // Cycles since reset, so that history checks never reach into reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r2_complementary: assert property (@(posedge clk) disable iff (rst)
    hck2 == !hck1);

  a_r2_half_duty: assert property (@(posedge clk) disable iff (rst)
    $rose(hck1) |=> (hck1 ##1 !hck1));

  a_r3_setup_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(hst) |=> $rose(hck1));

  a_r6_black_exclusive: assert property (@(posedge clk) disable iff (rst)
    sideBlack |-> (!hst && !hck1));

  a_r6_wide_no_black: assert property (@(posedge clk) disable iff (rst)
    (modeWide && $past(modeWide)) |-> !sideBlack);

  a_r8_flip_only_after_sync: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$stable(linePol)) |-> $past(lineSync, 2));

  a_r8_flip_after_every_sync: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(lineSync, 2)) |-> !$stable(linePol));

endmodule

bind delta_hdrive_gen dhg_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .lineSync (lineSync),
  .modeWide (modeWideQ),
  .hst      (hst),
  .hck1     (hck1),
  .hck2     (hck2),
  .sideBlack(sideBlack),
  .linePol  (linePol)
);

// File: tb/delta_hdrive_gen_tb_top.sv
`timescale 1ns/1ps
module delta_hdrive_gen_tb_top;

  logic clk = 1'b0;
  logic rst, lineSync, wideSel, rightSel;
  logic hst, hck1, hck2, sideBlack, linePol, scanDir;

  always #2 clk = ~clk;  // 250 MHz

  delta_hdrive_gen dut_i (
    .clk(clk), .rst(rst), .lineSync(lineSync), .wideSel(wideSel), .rightSel(rightSel),
    .hst(hst), .hck1(hck1), .hck2(hck2), .sideBlack(sideBlack),
    .linePol(linePol), .scanDir(scanDir)
  );

  typedef struct {
    int         stamp;
    logic [5:0] v;    // {hst, hck1, hck2, sideBlack, linePol, scanDir}
    string      tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    riseCnt = 0;
  logic  prevHck1 = 1'b0;
  bit    benchPar = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " hst"}, hst, 1'b0);
    chk({tag, " hck1"}, hck1, 1'b0);
    chk({tag, " hck2"}, hck2, 1'b1);
    chk({tag, " sideBlack"}, sideBlack, 1'b0);
    chk({tag, " linePol"}, linePol, 1'b0);
    chk({tag, " scanDir"}, scanDir, 1'b0);
  endtask

  // Expected outputs k ticks into a line, from the requirements alone.
  function automatic logic [5:0] model(int k, bit par, bit wide, bit right);
    int span, s, q, hOfs, stages;
    bit e_hst, e_h1, e_sb;
    span   = 2 + ((par == right) ? 6 : 0);   // R7
    s      = k - span;
    hOfs   = wide ? 0 : 176;                 // R5
    stages = wide ? 357 : 269;               // R4, R5
    q      = s - hOfs;
    e_hst  = (s >= 0) && (q >= 0) && (q < 4);                    // R3
    e_h1   = (s >= 0) && (q >= 1) && (q < 1 + stages * 4) && (((q - 1) % 4) < 2); // R2
    e_sb   = !wide && (s >= 0) && ((s < 176) || (s >= 1252 && s < 1428));           // R6
    return {e_hst, e_h1, !e_h1, e_sb, par, right};
  endfunction

  // Driver: called at a negedge; drives one line and queues its expectations.
  task automatic runLine(input bit wide, input bit right, input int len,
                         input bit endByReset, input int expEdges, input string tag);
    int c, n;
    c = cyc;
    benchPar = ~benchPar;
    lineSync = 1'b1; wideSel = wide; rightSel = right;
    riseCnt = 0;
    n = endByReset ? len - 1 : len;
    for (int k = 0; k < n; k++) sbq.push_back('{c + 2 + k, model(k, benchPar, wide, right), tag});
    @(negedge clk);
    lineSync = 1'b0;
    wideSel = ~wide; rightSel = ~right;   // R10: ignored until next sync
    repeat (len - 1) @(negedge clk);
    if (expEdges > 0) chkInt("R4 R5 hck1 rising edges per line", riseCnt, expEdges);
  endtask

  // Monitor: pops expectations when their cycle arrives.
  always @(negedge clk) begin
    if (hck1 === 1'b1 && prevHck1 === 1'b0) riseCnt++;
    prevHck1 = hck1;
    while (sbq.size() > 0 && sbq[0].stamp <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      if (it.stamp < cyc) begin
        chk({it.tag, " scoreboard slot missed"}, 1'b0, 1'b1);
      end else begin
        chk({it.tag, " R3 R4 R5 R7 hst"}, hst, it.v[5]);
        chk({it.tag, " R2 hck1"}, hck1, it.v[4]);
        chk({it.tag, " R2 hck2"}, hck2, it.v[3]);
        chk({it.tag, " R6 sideBlack"}, sideBlack, it.v[2]);
        chk({it.tag, " R8 linePol"}, linePol, it.v[1]);
        chk({it.tag, " R9 scanDir"}, scanDir, it.v[0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lineSync = 1'b0; wideSel = 1'b1; rightSel = 1'b1;
    repeat (3) @(negedge clk);
    chkIdle("R1 in reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chkIdle("R1 before first sync");

    runLine(1, 1, 1500, 0, 357, "R7 R10 R12 wide right odd");
    runLine(1, 1, 1500, 0, 357, "R7 R10 R12 wide right even");
    runLine(0, 1, 1500, 0, 269, "R5 R6 R10 narrow right odd");
    runLine(0, 1, 1500, 0, 269, "R5 R6 R10 narrow right even");
    runLine(1, 0, 1500, 0, 357, "R7 R9 R10 wide left odd");
    runLine(1, 0, 1500, 0, 357, "R7 R9 R10 wide left even");
    runLine(0, 0, 1500, 0, 269, "R6 R7 R10 narrow left odd");
    runLine(0, 0, 1500, 0, 269, "R6 R7 R10 narrow left even");
    runLine(0, 1, 300, 0, 0, "R11 cut short");
    runLine(1, 1, 1500, 0, 357, "R11 after restart");
    runLine(0, 0, 400, 1, 0, "R1 before reset");
    rst = 1'b1;
    @(negedge clk);
    chkIdle("R1 reset mid-line");
    rst = 1'b0;
    benchPar = 1'b0;
    @(negedge clk);
    runLine(1, 1, 1500, 0, 357, "R7 R8 first line after reset");
    repeat (4) @(negedge clk);
    chkInt("R12 scoreboard drained", sbq.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule